// File: doc/BRIEF.md
# Configurable Pixel Component Extractor

This block turns a stream of raw framebuffer bytes into red, green and blue pixel values. A format field says how many bytes form one pixel, from one to four. Bytes are collected into a pixel word with the first byte in the least significant position. Each colour channel has its own select word. That word gives the position of the channel's lowest bit in the pixel word, how many bits to take, and an 8-bit fallback colour.

A raster engine drives a pixel tick together with a visible-area flag and an underrun flag. On every tick the block registers one RGB pixel. When the tick falls inside the visible area, with no underrun and a complete word waiting, the fields are extracted and the word is consumed. In every other case the fallback colours are emitted and any waiting word is kept. A channel whose bit count is zero always shows its fallback. Each result is widened to 10 bits by left alignment and repetition of its top bits. This lets 16-, 24- and 32-bit layouts with 5-, 6-, 8- and 10-bit components share one output format.

Top module: `pixel_unpacker`

## Requirements
- R1: The byte count per pixel is fmtReg[4:3]+1. byteReady stays high until that many bytes have been accepted and then drops until the word is consumed.
- R2: Accepted bytes fill the pixel word little-endian: the first byte becomes bits [7:0], the second [15:8], and so on.
- R3: In each select word, bits [4:0] give the lowest extracted bit, bits [11:8] give the bit count and bits [23:16] give the 8-bit fallback. Counts above 10 act as 10.
- R4: An extracted field of w bits is placed at the top of the 10-bit output, and its bits are repeated downward from the MSB to fill the lower bits.
- R5: A channel whose bit count is 0 outputs its fallback as {fb[7:0], fb[7:6]}, while the other channels still extract.
- R6: A tick with inVisible low outputs the fallback on all channels, and the waiting word is neither consumed nor changed.
- R7: A tick with underrun high outputs the fallback on all channels, and the waiting word is kept.
- R8: Field bits above bit 31 of the pixel word read as zero.
- R9: Outputs change only on the edge that samples pixTick, and pixValid is high exactly in the cycle after a tick. Without a tick, the outputs hold.
- R10: After reset, byteReady is 1, pixValid is 0 and all channel outputs are 0.
- R11: A consumed word is cleared, so the bytes a narrower format does not fill read as zero.
- R12: A visible tick without underrun but with the word still incomplete outputs the fallbacks and consumes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| fmtReg | input | 32 | Format word; bits [4:3] hold bytes per pixel minus one |
| redSel | input | 32 | Red select word |
| grnSel | input | 32 | Green select word |
| bluSel | input | 32 | Blue select word |
| byteData | input | 8 | Framebuffer byte |
| byteValid | input | 1 | byteData is valid |
| byteReady | output | 1 | Block can take a byte |
| pixTick | input | 1 | Emit one pixel this cycle |
| inVisible | input | 1 | Raster is in the visible area |
| underrun | input | 1 | Pixel source has underrun |
| pixRed | output | 10 | Red result |
| pixGrn | output | 10 | Green result |
| pixBlu | output | 10 | Blue result |
| pixValid | output | 1 | Results were loaded on the last edge |

## Verification
Byte acceptance takes effect on the edge that samples byteValid, so byteReady, which is derived combinationally from the byte count, is checked at the falling edge after the last byte. A pixel result is registered on the edge that samples pixTick. The bench therefore raises pixTick at a falling edge, waits for one rising edge and samples every output and pixValid at the next falling edge. Retention under the fallback cases is checked by a later visible tick, which returns the stored word.

// File: rtl/pu_pkg.sv
package pu_pkg;
  localparam int SEL_W   = 32;
  localparam int OFF_LSB = 0;
  localparam int OFF_W   = 5;
  localparam int WID_LSB = 8;
  localparam int WID_W   = 4;
  localparam int DEF_LSB = 16;
  localparam int DEF_W   = 8;
  localparam int BPP_LSB = 3;

  typedef struct packed {
    logic loadByte;
    logic consume;
    logic emit;
  } puStrobe_t;
endpackage

// File: rtl/pu_chan.sv
module pu_chan
  import pu_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CHAN_W = 10
) (
  input  logic [WORD_W-1:0] word,
  input  logic [SEL_W-1:0]  sel,
  output logic [CHAN_W-1:0] fieldVal,
  output logic [CHAN_W-1:0] defVal,
  output logic              fieldOn
);
  logic [WORD_W-1:0] shifted;
  logic [WID_W-1:0]  width;
  logic [DEF_W-1:0]  defRaw;
  int                wEff;

  assign width   = sel[WID_LSB +: WID_W];
  assign defRaw  = sel[DEF_LSB +: DEF_W];
  assign shifted = word >> sel[OFF_LSB +: OFF_W];
  assign fieldOn = (width != '0);

  always_comb begin
    wEff = int'(width);
    if (wEff > CHAN_W) wEff = CHAN_W;
    if (wEff == 0) wEff = 1;
    for (int i = 0; i < CHAN_W; i++) begin
      fieldVal[i] = shifted[wEff - 1 - ((CHAN_W - 1 - i) % wEff)];
      defVal[i]   = defRaw[DEF_W - 1 - ((CHAN_W - 1 - i) % DEF_W)];
    end
  end
endmodule

// File: rtl/pu_ctrl.sv
module pu_ctrl
  import pu_pkg::*;
#(
  parameter int WORD_BYTES = 4,
  localparam int CNT_W = $clog2(WORD_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] bytesPerPix,
  input  logic             byteValid,
  input  logic             pixTick,
  input  logic             inVisible,
  input  logic             underrun,
  output logic             byteReady,
  output logic [CNT_W-1:0] byteIdx,
  output puStrobe_t        strb
);
  logic [CNT_W-1:0] byteCnt;
  logic             full;

  assign full      = (byteCnt >= bytesPerPix);
  assign byteReady = !full;
  assign byteIdx   = byteCnt;

  always_comb begin
    strb.loadByte = byteValid && !full;
    strb.consume  = pixTick && inVisible && !underrun && full;
    strb.emit     = pixTick;
  end

  always_ff @(posedge clk) begin
    if (!rstN) byteCnt <= '0;
    else if (strb.consume) byteCnt <= '0;
    else if (strb.loadByte) byteCnt <= byteCnt + 1'b1;
  end
endmodule

// File: rtl/pu_datapath.sv
module pu_datapath
  import pu_pkg::*;
#(
  parameter int WORD_BYTES = 4,
  parameter int CHAN_W = 10,
  localparam int CNT_W = $clog2(WORD_BYTES + 1),
  localparam int WORD_W = WORD_BYTES * 8,
  localparam int NCHAN = 3
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  puStrobe_t                    strb,
  input  logic [CNT_W-1:0]             byteIdx,
  input  logic [7:0]                   byteData,
  input  logic [NCHAN-1:0][SEL_W-1:0]  sels,
  output logic [NCHAN-1:0][CHAN_W-1:0] chanOut,
  output logic                         pixValid
);
  logic [WORD_W-1:0] word;

  for (genvar b = 0; b < WORD_BYTES; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rstN || strb.consume) word[b*8 +: 8] <= '0;
      else if (strb.loadByte && byteIdx == CNT_W'(b)) word[b*8 +: 8] <= byteData;
    end
  end

  for (genvar c = 0; c < NCHAN; c++) begin : g_chan
    logic [CHAN_W-1:0] fieldVal, defVal;
    logic              fieldOn;

    pu_chan #(.WORD_W(WORD_W), .CHAN_W(CHAN_W)) chan_i (
      .word(word), .sel(sels[c]), .fieldVal(fieldVal),
      .defVal(defVal), .fieldOn(fieldOn)
    );

    always_ff @(posedge clk) begin
      if (!rstN) chanOut[c] <= '0;
      else if (strb.emit) chanOut[c] <= (strb.consume && fieldOn) ? fieldVal : defVal;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) pixValid <= 1'b0;
    else pixValid <= strb.emit;
  end
endmodule

// File: rtl/pixel_unpacker.sv
module pixel_unpacker
  import pu_pkg::*;
#(
  parameter int WORD_BYTES = 4,
  parameter int CHAN_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [31:0]       fmtReg,
  input  logic [31:0]       redSel,
  input  logic [31:0]       grnSel,
  input  logic [31:0]       bluSel,
  input  logic [7:0]        byteData,
  input  logic              byteValid,
  output logic              byteReady,
  input  logic              pixTick,
  input  logic              inVisible,
  input  logic              underrun,
  output logic [CHAN_W-1:0] pixRed,
  output logic [CHAN_W-1:0] pixGrn,
  output logic [CHAN_W-1:0] pixBlu,
  output logic              pixValid
);
  localparam int CNT_W = $clog2(WORD_BYTES + 1);
  localparam int BPP_W = $clog2(WORD_BYTES);

  puStrobe_t               strb;
  logic [CNT_W-1:0]        byteIdx;
  logic [CNT_W-1:0]        bytesPerPix;
  logic [2:0][SEL_W-1:0]   sels;
  logic [2:0][CHAN_W-1:0]  chanOut;

  assign bytesPerPix = CNT_W'(fmtReg[BPP_LSB +: BPP_W]) + 1'b1;
  assign sels = {bluSel, grnSel, redSel};

  pu_ctrl #(.WORD_BYTES(WORD_BYTES)) ctrl_i (
    .clk(clk), .rstN(rstN), .bytesPerPix(bytesPerPix), .byteValid(byteValid),
    .pixTick(pixTick), .inVisible(inVisible), .underrun(underrun),
    .byteReady(byteReady), .byteIdx(byteIdx), .strb(strb)
  );

  pu_datapath #(.WORD_BYTES(WORD_BYTES), .CHAN_W(CHAN_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .byteIdx(byteIdx), .byteData(byteData),
    .sels(sels), .chanOut(chanOut), .pixValid(pixValid)
  );

  assign pixRed = chanOut[0];
  assign pixGrn = chanOut[1];
  assign pixBlu = chanOut[2];
endmodule

// File: rtl/pixel_unpacker_chk.sv
module pixel_unpacker_chk (
  input logic        clk,
  input logic        rstN,
  input logic [31:0] redSel,
  input logic [31:0] grnSel,
  input logic [31:0] bluSel,
  input logic        pixTick,
  input logic        inVisible,
  input logic        underrun,
  input logic [9:0]  pixRed,
  input logic [9:0]  pixGrn,
  input logic [9:0]  pixBlu,
  input logic        pixValid
);
  AST_VALID_AFTER_TICK: assert property (@(posedge clk) disable iff (!rstN)
    pixTick |=> pixValid); // R9
  AST_NO_VALID_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !pixTick |=> !pixValid); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !pixTick |=> ($stable(pixRed) && $stable(pixGrn) && $stable(pixBlu))); // R9
  AST_FALLBACK_INVIS: assert property (@(posedge clk) disable iff (!rstN)
    (pixTick && !inVisible) |=> (pixRed == {$past(redSel[23:16]), $past(redSel[23:22])})); // R6
  AST_FALLBACK_UNDERRUN: assert property (@(posedge clk) disable iff (!rstN)
    (pixTick && underrun) |=> (pixGrn == {$past(grnSel[23:16]), $past(grnSel[23:22])})); // R7
  AST_FALLBACK_ZERO_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    (pixTick && bluSel[11:8] == 4'd0) |=> (pixBlu == {$past(bluSel[23:16]), $past(bluSel[23:22])})); // R5
endmodule

bind pixel_unpacker pixel_unpacker_chk chk_i (
  .clk(clk), .rstN(rstN), .redSel(redSel), .grnSel(grnSel), .bluSel(bluSel),
  .pixTick(pixTick), .inVisible(inVisible), .underrun(underrun),
  .pixRed(pixRed), .pixGrn(pixGrn), .pixBlu(pixBlu), .pixValid(pixValid)
);

// File: tb/pixel_unpacker_tb_top.sv
module pixel_unpacker_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] fmtReg = '0, redSel = '0, grnSel = '0, bluSel = '0;
  logic [7:0]  byteData = '0;
  logic        byteValid = 1'b0, pixTick = 1'b0, inVisible = 1'b1, underrun = 1'b0;
  logic        byteReady, pixValid;
  logic [9:0]  pixRed, pixGrn, pixBlu;
  int          nChecks = 0, nFails = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  pixel_unpacker dut_i (
    .clk(clk), .rstN(rstN), .fmtReg(fmtReg), .redSel(redSel), .grnSel(grnSel),
    .bluSel(bluSel), .byteData(byteData), .byteValid(byteValid), .byteReady(byteReady),
    .pixTick(pixTick), .inVisible(inVisible), .underrun(underrun),
    .pixRed(pixRed), .pixGrn(pixGrn), .pixBlu(pixBlu), .pixValid(pixValid)
  );

  typedef struct packed {
    logic [31:0] fmt, rs, gs, bs, data;
    logic [9:0]  er, eg, eb;
  } vec_t;

  // select word = fallback<<16 | count<<8 | lowest bit
  localparam vec_t VECS [8] = '{
    '{32'h08, 32'h050B, 32'h0605, 32'h0500, 32'h0000A5C3, 10'h294, 10'h2EB, 10'h063}, // R2 R4 565
    '{32'h18, 32'h0810, 32'h0808, 32'h0800, 32'h001280FF, 10'h048, 10'h202, 10'h3FF}, // R3 x888
    '{32'h18, 32'h0800, 32'h0808, 32'h0810, 32'h003456C0, 10'h303, 10'h159, 10'h0D0}, // R3 bgr
    '{32'h18, 32'h0A14, 32'h0A0A, 32'h0A00, 32'h3A504AFF, 10'h3A5, 10'h012, 10'h2FF}, // R3 x10
    '{32'h10, 32'h0810, 32'h0808, 32'h0800, 32'h007F01AA, 10'h1FD, 10'h004, 10'h2AA}, // R1 888
    '{32'h08, 32'h050A, 32'h0505, 32'h0500, 32'h000083E0, 10'h000, 10'h3FF, 10'h000}, // R11 1555
    '{32'h18, 32'h081C, 32'h0100, 32'h011F, 32'hF0000000, 10'h03C, 10'h000, 10'h3FF}, // R8
    '{32'h00, 32'h5A0000, 32'h0404, 32'h0300, 32'h000000B7, 10'h169, 10'h2EE, 10'h3FF} // R5
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic sendWord(logic [31:0] fmt, logic [31:0] data);
    int nb;
    fmtReg = fmt;
    nb = int'(fmt[4:3]) + 1;
    for (int b = 0; b < nb; b++) begin
      @(negedge clk);
      byteValid = 1'b1;
      byteData  = data[b*8 +: 8];
      @(posedge clk);
    end
    @(negedge clk);
    byteValid = 1'b0;
  endtask

  task automatic tick(logic vis, logic und);
    @(negedge clk);
    pixTick = 1'b1; inVisible = vis; underrun = und;
    @(posedge clk);
    @(negedge clk);
    pixTick = 1'b0; inVisible = 1'b1; underrun = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 ready", 32'(byteReady), 1);
    check("R10 valid", 32'(pixValid), 0);
    check("R10 red", 32'(pixRed), 0);
    rstN = 1'b1;

    for (int v = 0; v < 8; v++) begin
      redSel = VECS[v].rs; grnSel = VECS[v].gs; bluSel = VECS[v].bs;
      sendWord(VECS[v].fmt, VECS[v].data);
      check("R1 ready low when full", 32'(byteReady), 0);
      tick(1'b1, 1'b0);
      check("R9 valid", 32'(pixValid), 1);
      check("R2/R3/R4 red", 32'(pixRed), 32'(VECS[v].er));
      check("R2/R3/R4 green", 32'(pixGrn), 32'(VECS[v].eg));
      check("R2/R3/R4 blue", 32'(pixBlu), 32'(VECS[v].eb));
    end

    // R11: wide word of ones, then one byte of zero read at bits [15:8]
    redSel = 32'h0808; grnSel = 32'h0800; bluSel = 32'h0800;
    sendWord(32'h18, 32'hFFFFFFFF);
    tick(1'b1, 1'b0);
    sendWord(32'h00, 32'h00);
    tick(1'b1, 1'b0);
    check("R11 cleared upper byte", 32'(pixRed), 0);

    // R6: invisible tick gives fallbacks, word kept
    redSel = 32'hFF050B; grnSel = 32'h000605; bluSel = 32'h800500;
    sendWord(32'h08, 32'h0000A5C3);
    tick(1'b0, 1'b0);
    check("R6 red fallback", 32'(pixRed), 32'h3FF);
    check("R6 green fallback", 32'(pixGrn), 32'h000);
    check("R6 blue fallback", 32'(pixBlu), 32'h202);
    check("R6 word kept", 32'(byteReady), 0);

    // R7: underrun tick gives fallbacks, word kept
    tick(1'b1, 1'b1);
    check("R7 red fallback", 32'(pixRed), 32'h3FF);
    check("R7 blue fallback", 32'(pixBlu), 32'h202);
    check("R7 word kept", 32'(byteReady), 0);
    tick(1'b1, 1'b0);
    check("R6/R7 retained red", 32'(pixRed), 32'h294);
    check("R6/R7 retained green", 32'(pixGrn), 32'h2EB);
    check("R6/R7 ready after consume", 32'(byteReady), 1);

    // R12: visible tick with empty word
    tick(1'b1, 1'b0);
    check("R12 red fallback", 32'(pixRed), 32'h3FF);
    check("R12 valid", 32'(pixValid), 1);
    check("R12 nothing consumed", 32'(byteReady), 1);

    // R9: idle cycle holds outputs
    @(negedge clk);
    check("R9 valid low idle", 32'(pixValid), 0);
    check("R9 red held", 32'(pixRed), 32'h3FF);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule